// File: doc/BRIEF.md
# T1 Dual-Rail Receive Input Stage

This block is the front end of a T1 receive path. The line arrives on two unipolar rails. One rail carries positive marks and the other carries negative marks. Both rails are captured on the falling edge of the already-recovered receive clock and merged into a single NRZ bit stream. The stream passes through a fixed delay line, so a bit leaves on the serial output exactly 13 rising edges after it was presented. That lines the data up with the downstream framer timing.

While the stream is merged, a small line-mode state machine watches the rail pair. It has two states:

- **LINE_BIPOLAR**: alternate-mark checking is active.
- **LINE_NRZ**: the rails are treated as one shorted NRZ signal, and no violations are reported.

The transitions are as follows:

- **enter_nrz** fires from LINE_BIPOLAR after `MATCH_RUN` samples with both rails high, with no sample in between where the rails differ. Zero samples neither count nor break the run.
- **exit_nrz** fires from LINE_NRZ on the first sample where the rails differ.
- **hold** covers every other case.
- A static input, `nrz_force`, pins the stage in NRZ behaviour regardless of the state.

A registered bipolar-violation pin reports each offending bit one clock after its capture.

Top module: `t1_rail_rx`

## Requirements
- R1: The merged bit is 1 when either rail is high in the sample and 0 when both rails are low.
- R2: A bit presented in the clock period that begins at rising edge t appears on `ser_out` right after rising edge t+13. `ser_out` changes only at rising edges.
- R3: In bipolar behaviour, a sample with both rails high raises `bpv_out`.
- R4: While `nrz_active` is high, the next value of `bpv_out` is 0 for any rail pattern.
- R5: In bipolar behaviour, a single-rail mark of the same polarity as the previous single-rail mark raises `bpv_out`, however many zero samples lie between them. A mark of opposite polarity does not.
- R6: From LINE_BIPOLAR, the `MATCH_RUN`-th both-high sample of a run moves the stage to LINE_NRZ (`nrz_active` rises one clock later). Zero samples do not reset the run, and a sample where the rails differ clears it.
- R7: In LINE_NRZ, any sample where the rails differ returns the stage to LINE_BIPOLAR.
- R8: With `nrz_force` high, `nrz_active` is 1 and no violation is flagged.
- R9: The rails are sampled on the falling clock edge, and rail changes after that edge do not affect the sample. `bpv_out` for a sample is valid for the whole period after the following rising edge.
- R10: A synchronous reset clears the delay line, `bpv_out`, the run counter, the state and the last-mark memory. After reset `ser_out` is 0 for 13 clocks, and the first mark is never a violation.
- R11: Bipolar and NRZ behaviour keep no shared mark memory. The first single-rail mark after leaving NRZ behaviour is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_pos | input | 1 | Positive-mark rail |
| rail_neg | input | 1 | Negative-mark rail |
| nrz_force | input | 1 | Static request for NRZ behaviour |
| ser_out | output | 1 | Delayed merged NRZ data |
| bpv_out | output | 1 | Bipolar-violation status, one clock per bad bit |
| nrz_active | output | 1 | High while NRZ behaviour is in effect |

## Verification
The bench sweeps every three-sample rail pattern from reset. A design that sampled on the rising edge would be caught by rail garbage driven after each falling edge. A design that remembered marks across reset would flag the first mark after reset. The bench also probes the run boundary for NRZ entry with zero samples inside the run. A counter that reset on zeros, or one off by one, would enter late or early and flag or drop violations. Leaving NRZ is checked to forget the last polarity, and the serial output is checked against a 13-clock reference delay. A short or long pipeline would mismatch on every cycle.

// File: rtl/t1rx_pkg.sv
package t1rx_pkg;
    typedef enum logic {
        LINE_BIPOLAR = 1'b0,
        LINE_NRZ     = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic valid;
        logic pos;
    } mark_mem_t;
endpackage

// File: rtl/t1rx_rail_sampler.sv
module t1rx_rail_sampler (
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic neg_i,
    output logic pos_s,
    output logic neg_s
);
    // Capture on the falling edge, mid-bit of the recovered clock.
    always_ff @(negedge clk) begin
        if (rst) begin
            pos_s <= 1'b0;
            neg_s <= 1'b0;
        end else begin
            pos_s <= pos_i;
            neg_s <= neg_i;
        end
    end
endmodule

// File: rtl/t1rx_line_monitor.sv
module t1rx_line_monitor
    import t1rx_pkg::*;
#(
    parameter int MATCH_RUN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pos_s,
    input  logic neg_s,
    input  logic force_nrz,
    output logic bpv_o,
    output logic nrz_o
);
    localparam int RUN_W = $clog2(MATCH_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MATCH_RUN - 1);

    line_mode_e       state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    mark_mem_t        mem_q, mem_d;
    logic             bpv_d;
    logic             both, split, active;

    assign both   = pos_s & neg_s;
    assign split  = pos_s ^ neg_s;
    assign active = force_nrz | (state_q == LINE_NRZ);
    assign nrz_o  = active;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINE_BIPOLAR;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // Transitions: enter_nrz, exit_nrz, hold
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            LINE_BIPOLAR: begin
                if (both) begin
                    if (run_q == RUN_LAST) begin
                        state_d = LINE_NRZ;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + RUN_W'(1);
                    end
                end else if (split) begin
                    run_d = '0;
                end
            end
            LINE_NRZ: begin
                if (split) begin
                    state_d = LINE_BIPOLAR;
                    run_d   = '0;
                end
            end
            default: begin
                state_d = LINE_BIPOLAR;
                run_d   = '0;
            end
        endcase
    end

    // Violation decision and mark memory
    always_comb begin
        bpv_d = 1'b0;
        mem_d = mem_q;
        if (active) begin
            mem_d = '0;
        end else if (both) begin
            bpv_d = 1'b1;
        end else if (split) begin
            bpv_d     = mem_q.valid && (mem_q.pos == pos_s);
            mem_d.valid = 1'b1;
            mem_d.pos   = pos_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bpv_o <= 1'b0;
            mem_q <= '0;
        end else begin
            bpv_o <= bpv_d;
            mem_q <= mem_d;
        end
    end

    assert_both_high_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!nrz_o && pos_s && neg_s) |=> bpv_o);

    assert_quiet_in_nrz_R4: assert property (@(posedge clk) disable iff (rst)
        nrz_o |=> !bpv_o);

    assert_enter_nrz_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINE_BIPOLAR && pos_s && neg_s && run_q == RUN_LAST)
        |=> (state_q == LINE_NRZ && nrz_o));

    assert_exit_nrz_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINE_NRZ && (pos_s != neg_s)) |=> (state_q == LINE_BIPOLAR));
endmodule

// File: rtl/t1rx_delay_line.sv
module t1rx_delay_line #(
    parameter int LATENCY = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int STAGES = LATENCY;

    logic [STAGES-1:0] pipe;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= 1'b0;
                else     pipe[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 1'b0;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/t1_rail_rx.sv
module t1_rail_rx #(
    parameter int LATENCY   = 13,
    parameter int MATCH_RUN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rail_pos,
    input  logic rail_neg,
    input  logic nrz_force,
    output logic ser_out,
    output logic bpv_out,
    output logic nrz_active
);
    logic pos_s, neg_s, merged;

    t1rx_rail_sampler u_sampler (
        .clk   (clk),
        .rst   (rst),
        .pos_i (rail_pos),
        .neg_i (rail_neg),
        .pos_s (pos_s),
        .neg_s (neg_s)
    );

    assign merged = pos_s | neg_s;

    t1rx_line_monitor #(.MATCH_RUN(MATCH_RUN)) u_monitor (
        .clk       (clk),
        .rst       (rst),
        .pos_s     (pos_s),
        .neg_s     (neg_s),
        .force_nrz (nrz_force),
        .bpv_o     (bpv_out),
        .nrz_o     (nrz_active)
    );

    t1rx_delay_line #(.LATENCY(LATENCY)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (merged),
        .dout (ser_out)
    );
endmodule

// File: tb/sim_t1_rail_rx.sv
module sim_t1_rail_rx;
    localparam int LAT = 13;
    localparam int RUN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rail_pos = 1'b0;
    logic rail_neg = 1'b0;
    logic nrz_force = 1'b0;
    logic ser_out, bpv_out, nrz_active;

    t1_rail_rx #(.LATENCY(LAT), .MATCH_RUN(RUN)) u0 (
        .clk(clk), .rst(rst), .rail_pos(rail_pos), .rail_neg(rail_neg),
        .nrz_force(nrz_force), .ser_out(ser_out), .bpv_out(bpv_out),
        .nrz_active(nrz_active)
    );

    always #5 clk = ~clk;   // 100 MHz

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    bit m_st, m_lv, m_lp, m_fresh;
    int m_run;
    bit hist [0:8191];
    int idx;
    bit e_bpv, e_nrz;
    string l_bpv, l_nrz;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at idx %0d", tag, act, exp, idx);
        end
    endtask

    task automatic do_reset(input bit f);
        @(posedge clk); #1;
        rst = 1'b1;
        nrz_force = f;
        rail_pos = 1'b0;
        rail_neg = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 ser_out in reset", ser_out, 1'b0);
        chk("R10 bpv_out in reset", bpv_out, 1'b0);
        chk("R10 nrz_active in reset", nrz_active, f);
        m_st = 0; m_lv = 0; m_lp = 0; m_run = 0; m_fresh = 1;
        idx = 0;
        e_bpv = 0; e_nrz = f;
        l_bpv = "R10 bpv_out"; l_nrz = "R10 nrz_active";
    endtask

    task automatic step(input bit p, input bit n);
        bit act, ser_e, prev_st;
        @(posedge clk); #1;
        chk(l_bpv, bpv_out, e_bpv);
        chk(l_nrz, nrz_active, e_nrz);
        ser_e = (idx >= LAT) ? hist[(idx - LAT) % 8192] : 1'b0;
        chk((idx >= LAT) ? "R1/R2 ser_out" : "R10 ser_out", ser_out, ser_e);
        rst = 1'b0;
        rail_pos = p;
        rail_neg = n;
        hist[idx % 8192] = p | n;
        idx++;
        // expected behaviour of this sample, from the requirements
        act = nrz_force | m_st;
        if (act) begin
            e_bpv = 0; l_bpv = nrz_force ? "R8/R4 bpv_out" : "R4/R9 bpv_out";
            m_lv = 0;
        end else if (p & n) begin
            e_bpv = 1; l_bpv = "R3/R9 bpv_out";
        end else if (p ^ n) begin
            e_bpv = m_lv && (m_lp == p);
            if (!m_lv) l_bpv = m_fresh ? "R10 first mark" : "R11 first mark";
            else       l_bpv = "R5/R9 bpv_out";
            m_lv = 1; m_lp = p; m_fresh = 0;
        end else begin
            e_bpv = 0; l_bpv = "R5/R9 bpv_out zero";
        end
        prev_st = m_st;
        if (!m_st) begin
            if (p & n) begin
                if (m_run == RUN - 1) begin m_st = 1; m_run = 0; end
                else m_run++;
            end else if (p ^ n) m_run = 0;
        end else if (p ^ n) begin
            m_st = 0; m_run = 0;
        end
        e_nrz = nrz_force | m_st;
        if (nrz_force)              l_nrz = "R8 nrz_active";
        else if (m_st && !prev_st)  l_nrz = "R6 nrz_active entry";
        else if (!m_st && prev_st)  l_nrz = "R7 nrz_active exit";
        else                        l_nrz = "R6/R7 nrz_active";
        // R9: garbage after the falling edge must not be seen
        @(negedge clk); #1;
        rail_pos = 1'($urandom);
        rail_neg = 1'($urandom);
    endtask

    task automatic flush();
        for (int k = 0; k < LAT + 2; k++) step(0, 0);
    endtask

    initial begin
        bit pol;
        // Exhaustive three-sample sweep from reset (R1, R3, R5, R9, R10)
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int c = 0; c < 4; c++) begin
                    do_reset(0);
                    step(a[1], a[0]);
                    step(b[1], b[0]);
                    step(c[1], c[0]);
                    flush();
                end
            end
        end

        // Clean alternate-mark stream: no violations (R5)
        do_reset(0);
        pol = 0;
        for (int k = 0; k < 300; k++) begin
            if ($urandom % 2) begin
                step(pol, !pol);
                pol = !pol;
            end else step(0, 0);
        end
        flush();

        // Same polarity separated by zeros (R5)
        do_reset(0);
        step(1, 0); step(0, 0); step(0, 0); step(1, 0);
        step(0, 1); step(0, 0); step(0, 1); step(1, 0);
        flush();

        // NRZ entry at the run boundary with zeros inside the run (R6, R3)
        do_reset(0);
        step(1, 1); step(1, 1); step(0, 0); step(1, 1);
        step(1, 0);                 // differing sample clears the run
        step(1, 1); step(1, 1); step(0, 0); step(1, 1); step(1, 1);
        for (int k = 0; k < 200; k++) begin
            bit v;
            v = 1'($urandom);
            step(v, v);             // R4: shorted rails, no flags
        end
        step(1, 0);                 // R7 exit
        step(0, 0);
        step(1, 0);                 // R11: first mark after exit
        step(1, 0);                 // R5: same polarity now flags
        flush();

        // Random dual-rail traffic (R1, R3, R5, R6, R7)
        do_reset(0);
        for (int k = 0; k < 3000; k++) step(1'($urandom), 1'($urandom));
        flush();

        // Forced NRZ (R8)
        do_reset(1);
        for (int k = 0; k < 400; k++) step(1'($urandom), 1'($urandom));
        flush();

        // Reset in the middle of marks clears memory (R10)
        do_reset(0);
        step(1, 0); step(0, 0); step(1, 1);
        do_reset(0);
        step(1, 0); step(1, 0);
        flush();

        @(posedge clk); #1;
        chk("R5/R9 bpv_out final", bpv_out, e_bpv);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog all requirements actual=%0d expected<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule